// File: doc/BRIEF.md
# Super-I/O Configuration Port with GPIO Banks

This block gives a host the configuration side of a legacy Super-I/O device over a narrow 8-bit I/O-port bus. The bus has two ports. The index port (`io_addr` = 0) selects a register number. The data port (`io_addr` = 1) reads or writes the register that was selected. Configuration space starts locked. It opens only after a fixed unlock byte has been written twice in a row to the index port, and it closes again on a separate lock byte.

Inside configuration space, the block holds a logical-device select register and read-only identification registers. It also holds a set of GPIO banks. The banks can be reached only while the GPIO logical device is selected. Each bank has four registers: direction, output data, sampled pin level and output mode. These registers drive the pad outputs and pad enables directly. Each pin can be an input, a push-pull output or an open-drain output. Read data is combinational and is valid in the cycle `io_rd` is high. A write takes effect at the clock edge on which `io_wr` is sampled high.

Top module: `sio_cfg_port`

## Requirements
- R1: Configuration mode (`cfg_active` = 1) is entered one cycle after the second of two consecutive index-port writes of 0x87. Any other index-port write in between restarts the detection.
- R2: An index-port write of 0xAA leaves configuration mode. While locked, data-port writes change nothing, and data-port reads return 0xFF.
- R3: While configuration mode is active, a data-port access targets the register whose number was last written to the index port, and an index-port read returns that number. While locked, an index-port read returns 0xFF. When `io_rd` is low, `io_rdata` is 0x00.
- R4: Index 0x07 is a read/write logical-device register. The bank registers are decoded only while it holds 0x06. Otherwise those indices read 0x00 and writes to them are ignored.
- R5: These registers are read-only and ignore writes: 0x20 = device ID high byte, 0x21 = device ID low byte, 0x22 = revision, 0x23 = 0x19 and 0x24 = 0x34 (vendor ID 0x1934, high byte first).
- R6: Bank b has its base at 0xF0 − 0x10·b. Base+0 is direction (1 = output), base+1 is output data, base+2 is the pin level and base+3 is the output mode (1 = push-pull, 0 = open-drain).
- R7: Pins that are not implemented in a bank read as 0 in every register and ignore writes. Undecoded indices read 0x00. The default pin masks are 0xFF, 0xFF, 0x3F and 0x1F for banks 0 to 3.
- R8: For a push-pull output, `pad_oe` equals the direction bit, and `pad_out` equals the output data bit. An input pin has `pad_oe` = 0 and `pad_out` = 0.
- R9: For an open-drain output, `pad_oe` is 1 only while the output data bit is 0, and `pad_out` stays 0.
- R10: The pin-level register returns `pad_in` after a two-flop synchroniser, so a level change shows on reads two edges later. Writes to this register are ignored.
- R11: After reset, configuration mode is off, the logical-device register is 0, and every direction, output data and mode bit is 0. As a result, all pads are undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | Bus write strobe |
| io_rd | input | 1 | Bus read strobe |
| io_addr | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Bus read data (combinational) |
| pad_in | input | NUM_BANKS*8 | Pad input levels, bank b at bits [8b+7:8b] |
| pad_out | output | NUM_BANKS*8 | Pad output values |
| pad_oe | output | NUM_BANKS*8 | Pad output enables |
| cfg_active | output | 1 | Configuration mode is open |

## Verification
A wrong key-detector state shows at `cfg_active` on the clock edge after the offending index write. It also shows at the next data-port read, which then returns 0xFF where a value was expected, or the reverse. A corrupted direction, data or mode bit changes `pad_oe` or `pad_out` within one cycle, so the per-cycle comparison of the pads against a reference model catches it at once. A bad index or logical-device register can hide until the next read. For that reason, the bench reads back every register class after writing it, and also runs a long stretch of randomly mixed accesses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0]  KEY_ENTER   = 8'h87;
  localparam logic [7:0]  KEY_EXIT    = 8'hAA;
  localparam logic [7:0]  IDX_LDN     = 8'h07;
  localparam logic [7:0]  IDX_DEV_HI  = 8'h20;
  localparam logic [7:0]  IDX_DEV_LO  = 8'h21;
  localparam logic [7:0]  IDX_REV     = 8'h22;
  localparam logic [7:0]  IDX_VEN_HI  = 8'h23;
  localparam logic [7:0]  IDX_VEN_LO  = 8'h24;
  localparam logic [7:0]  LDN_GPIO    = 8'h06;
  localparam logic [15:0] VENDOR_ID   = 16'h1934;
  localparam int          BANK_TOP    = 'hF0;
  localparam int          BANK_STRIDE = 'h10;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;
  typedef enum logic [1:0] {REG_DIR = 2'd0, REG_DOUT = 2'd1,
                            REG_PIN = 2'd2, REG_MODE = 2'd3} bank_reg_e;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open
);
  key_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    if (idx_wr) begin
      if (state_q == KS_OPEN) begin
        if (wdata == KEY_EXIT) state_n = KS_LOCKED;
      end else if (wdata == KEY_ENTER) begin
        state_n = (state_q == KS_HALF) ? KS_OPEN : KS_HALF;
      end else begin
        state_n = KS_LOCKED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_n;
  end

  assign cfg_open = (state_q == KS_OPEN);
endmodule

// File: rtl/sio_gpio_bank.sv
module sio_gpio_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] PIN_MASK = 8'hFF,
  parameter logic [7:0] BASE     = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  input  logic [7:0] pad_in,
  output logic       rd_hit,
  output logic [7:0] rd_data,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe
);
  logic [7:0] dir_q, dout_q, mode_q, sync1_q, sync2_q;
  logic [7:0] dir_n, dout_n, mode_n;
  bank_reg_e  off;

  assign rd_hit = (idx[7:2] == BASE[7:2]);
  assign off    = bank_reg_e'(idx[1:0]);

  always_comb begin
    dir_n  = dir_q;
    dout_n = dout_q;
    mode_n = mode_q;
    if (wr_en && rd_hit) begin
      case (off)
        REG_DIR:  dir_n  = wdata & PIN_MASK;
        REG_DOUT: dout_n = wdata & PIN_MASK;
        REG_MODE: mode_n = wdata & PIN_MASK;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      dir_q   <= dir_n;
      dout_q  <= dout_n;
      mode_q  <= mode_n;
      sync1_q <= pad_in & PIN_MASK;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (off)
      REG_DIR:  rd_data = dir_q;
      REG_DOUT: rd_data = dout_q;
      REG_PIN:  rd_data = sync2_q;
      default:  rd_data = mode_q;
    endcase
  end

  // open-drain pulls low only; push-pull drives both levels
  assign pad_oe  = dir_q & (mode_q | ~dout_q);
  assign pad_out = dir_q & mode_q & dout_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_BANKS     = 4,
  parameter logic [NUM_BANKS*8-1:0] BANK_PIN_MASK = 32'h1F3F_FFFF,
  parameter logic [15:0] DEVICE_ID     = 16'h0A51,
  parameter logic [7:0]  REVISION      = 8'h03,
  localparam int         NPINS         = NUM_BANKS * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             cfg_active
);
  logic       rst_meta, rst_q;
  logic [7:0] idx_q, idx_n, ldn_q, ldn_n;
  logic       cfg_open, idx_wr, dat_wr, gpio_sel;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [7:0] bank_rd [NUM_BANKS];
  logic [7:0] rd_val, bank_val;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign idx_wr   = io_wr & ~io_addr;
  assign dat_wr   = io_wr & io_addr & cfg_open;
  assign gpio_sel = (ldn_q == LDN_GPIO);

  sio_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_q),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .cfg_open (cfg_open)
  );

  always_comb begin
    idx_n = idx_q;
    ldn_n = ldn_q;
    if (cfg_open && idx_wr && io_wdata != KEY_EXIT) idx_n = io_wdata;
    if (dat_wr && idx_q == IDX_LDN)                 ldn_n = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      idx_q <= idx_n;
      ldn_q <= ldn_n;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [7:0] BASE = 8'(BANK_TOP - BANK_STRIDE * b);
    sio_gpio_bank #(
      .PIN_MASK (BANK_PIN_MASK[b*8 +: 8]),
      .BASE     (BASE)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_en   (dat_wr & gpio_sel),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .pad_in  (pad_in[b*8 +: 8]),
      .rd_hit  (bank_hit[b]),
      .rd_data (bank_rd[b]),
      .pad_out (pad_out[b*8 +: 8]),
      .pad_oe  (pad_oe[b*8 +: 8])
    );
  end

  always_comb begin
    bank_val = 8'h00;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_hit[b]) bank_val = bank_val | bank_rd[b];
  end

  always_comb begin
    rd_val = 8'h00;
    if (!cfg_open)     rd_val = 8'hFF;
    else if (!io_addr) rd_val = idx_q;
    else begin
      case (idx_q)
        IDX_LDN:    rd_val = ldn_q;
        IDX_DEV_HI: rd_val = DEVICE_ID[15:8];
        IDX_DEV_LO: rd_val = DEVICE_ID[7:0];
        IDX_REV:    rd_val = REVISION;
        IDX_VEN_HI: rd_val = VENDOR_ID[15:8];
        IDX_VEN_LO: rd_val = VENDOR_ID[7:0];
        default:    rd_val = gpio_sel ? bank_val : 8'h00;
      endcase
    end
  end

  assign io_rdata   = io_rd ? rd_val : 8'h00;
  assign cfg_active = cfg_open;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NPINS = 32,
  parameter logic [NPINS-1:0] PIN_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_wr,
  input logic             io_rd,
  input logic             io_addr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic             cfg_active
);
  // R1
  enter_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_active) |-> $past(io_wr && !io_addr && io_wdata == 8'h87));

  // R2
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> $past(io_wr && !io_addr && io_wdata == 8'hAA));

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && io_rd && io_addr) |-> io_rdata == 8'hFF);

  // R2
  locked_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> ($stable(pad_oe) && $stable(pad_out)));

  // R7
  unimpl_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~PIN_MASK) == '0);

  // R8
  drive_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .NPINS    (NPINS),
  .PIN_MASK (BANK_PIN_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .cfg_active (cfg_active)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam int NB = 4;
  localparam int NP = NB * 8;
  localparam logic [NP-1:0] PMASK = 32'h1F3F_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic cfg_active;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sio_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .cfg_active(cfg_active)
  );

  // behavioural reference state
  bit         m_open, m_half;
  logic [7:0] m_idx, m_ldn;
  logic [7:0] m_dir [NB];
  logic [7:0] m_dout[NB];
  logic [7:0] m_mode[NB];
  logic [NP-1:0] m_s1, m_s2;

  function automatic logic [7:0] bmask(int b);
    return PMASK[b*8 +: 8];
  endfunction

  function automatic logic [7:0] m_read(bit addr);
    int base;
    if (!m_open) return 8'hFF;
    if (!addr) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h0A;
      8'h21: return 8'h51;
      8'h22: return 8'h03;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: ;
    endcase
    if (m_ldn != 8'h06) return 8'h00;
    for (int b = 0; b < NB; b++) begin
      base = 'hF0 - 'h10 * b;
      if (int'(m_idx) == base)     return m_dir[b];
      if (int'(m_idx) == base + 1) return m_dout[b];
      if (int'(m_idx) == base + 2) return m_s2[b*8 +: 8];
      if (int'(m_idx) == base + 3) return m_mode[b];
    end
    return 8'h00;
  endfunction

  task automatic m_reset();
    m_open = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_s1 = '0; m_s2 = '0;
    for (int b = 0; b < NB; b++) begin
      m_dir[b] = 0; m_dout[b] = 0; m_mode[b] = 0;
    end
  endtask

  task automatic m_step(bit wr, bit addr, logic [7:0] d);
    int base;
    logic [7:0] old_idx = m_idx;
    bit was_open = m_open;
    m_s2 = m_s1;
    m_s1 = pad_in & PMASK;
    if (wr && !addr) begin
      if (m_open) begin
        if (d == 8'hAA) m_open = 0; else m_idx = d;
      end else if (d == 8'h87) begin
        if (m_half) begin m_open = 1; m_half = 0; end
        else m_half = 1;
      end else m_half = 0;
    end
    if (wr && addr && was_open) begin
      if (old_idx == 8'h07) m_ldn = d;
      else if (m_ldn == 8'h06) begin
        for (int b = 0; b < NB; b++) begin
          base = 'hF0 - 'h10 * b;
          if (int'(old_idx) == base)     m_dir[b]  = d & bmask(b);
          if (int'(old_idx) == base + 1) m_dout[b] = d & bmask(b);
          if (int'(old_idx) == base + 3) m_mode[b] = d & bmask(b);
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_pads();
    logic [NP-1:0] e_oe, e_out;
    for (int p = 0; p < NP; p++) begin
      bit dr = m_dir[p/8][p%8];
      bit dv = m_dout[p/8][p%8];
      bit pp = m_mode[p/8][p%8];
      e_oe[p] = 0; e_out[p] = 0;
      if (dr && pp) begin e_oe[p] = 1; e_out[p] = dv; end
      else if (dr && !dv) e_oe[p] = 1;
    end
    chk("R8 R9 pad_oe", pad_oe, e_oe);
    chk("R8 R9 pad_out", pad_out, e_out);
    chk("R1 cfg_active", cfg_active, m_open);
  endtask

  task automatic cyc(bit wr, bit rd, bit addr, logic [7:0] d, string tag);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = addr; io_wdata = d;
    #1;
    if (rd) chk(tag, io_rdata, m_read(addr));
    else    chk("R3 idle rdata", io_rdata, 8'h00);
    @(posedge clk);
    m_step(wr, addr, d);
    #1;
    chk_pads();
    io_wr = 0; io_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00, "idle");
  endtask
  task automatic wi(logic [7:0] d); cyc(1, 0, 0, d, "wr_idx"); endtask
  task automatic wd(logic [7:0] d); cyc(1, 0, 1, d, "wr_dat"); endtask
  task automatic rd(string tag);    cyc(0, 1, 1, 8'h00, tag); endtask
  task automatic reg_wr(logic [7:0] i, logic [7:0] d); wi(i); wd(d); endtask
  task automatic reg_rd(logic [7:0] i, string tag);    wi(i); rd(tag); endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_reset();
    repeat (4) @(posedge clk);
    #1;
    chk("R11 reset oe", pad_oe, '0);
    chk("R11 reset out", pad_out, '0);
    chk("R11 reset cfg", cfg_active, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // locked access
    rd("R2 locked data read");
    cyc(0, 1, 0, 8'h00, "R3 locked index read");
    wd(8'h55);

    // key detection with interruption
    wi(8'h87); wi(8'h55); wi(8'h87);
    chk("R1 interrupted key", cfg_active, 0);
    wi(8'h87);
    chk("R1 entered", cfg_active, 1);
    cyc(0, 1, 0, 8'h00, "R3 index read");

    // identification
    reg_rd(8'h20, "R5 dev hi"); reg_rd(8'h21, "R5 dev lo");
    reg_rd(8'h22, "R5 rev");    reg_rd(8'h23, "R5 ven hi");
    reg_rd(8'h24, "R5 ven lo");
    reg_wr(8'h23, 8'h00); rd("R5 ven hi after write");
    reg_rd(8'h07, "R11 ldn reset");

    // bank access without GPIO device selected
    reg_wr(8'hF0, 8'hFF); rd("R4 bank hidden");
    reg_wr(8'h07, 8'h05); reg_rd(8'hF0, "R4 other ldn");
    reg_wr(8'h07, 8'h06); reg_rd(8'h07, "R4 ldn readback");
    reg_rd(8'hF0, "R4 write was ignored");

    // bank registers
    for (int b = 0; b < NB; b++) begin
      logic [7:0] base = 8'(8'hF0 - 8'h10 * b);
      reg_wr(base + 8'd1, 8'hA5 ^ 8'(b));
      reg_wr(base + 8'd3, 8'h3C);
      reg_wr(base, 8'hFF);
      reg_rd(base, "R6 dir"); reg_rd(base + 8'd1, "R6 dout");
      reg_rd(base + 8'd3, "R6 mode");
      reg_wr(base + 8'd2, 8'hFF); rd("R10 pin reg write ignored");
    end
    reg_wr(8'hC0, 8'hFF); rd("R7 bank3 mask");
    reg_rd(8'hF4, "R7 undecoded F4"); reg_rd(8'h50, "R7 undecoded 50");

    // open-drain / push-pull combinations
    reg_wr(8'hF3, 8'h00); reg_wr(8'hF1, 8'h0F); idle(1);
    chk("R9 open drain oe", pad_oe[7:0], 8'hF0);
    reg_wr(8'hF3, 8'hFF); idle(1);
    chk("R8 push pull out", pad_out[7:0], 8'h0F);
    reg_wr(8'hF0, 8'h00); idle(1);
    chk("R8 inputs undriven", pad_oe[7:0], 8'h00);

    // input synchroniser
    pad_in = 32'hDEAD_BEEF;
    wi(8'hE2);
    rd("R10 one edge");
    rd("R10 two edges");
    pad_in = 32'h1234_5678; idle(2);
    reg_rd(8'hD2, "R10 masked bank2"); reg_rd(8'hC2, "R10 masked bank3");

    // exit and locked writes
    wi(8'hAA);
    chk("R2 exited", cfg_active, 0);
    wd(8'h00); rd("R2 locked read");
    wi(8'h87); wi(8'h87);
    reg_rd(8'hE0, "R2 state kept"); reg_rd(8'h07, "R2 ldn kept");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] v = 8'($urandom);
      if (sel < 3) begin
        logic [7:0] ix;
        case ($urandom_range(0, 7))
          0: ix = 8'h87; 1: ix = 8'hAA; 2: ix = 8'h07; 3: ix = 8'h20;
          default: ix = 8'(8'hF0 - 8'h10 * $urandom_range(0, NB)) + 8'($urandom_range(0, 3));
        endcase
        wi(ix);
      end else if (sel < 5) begin
        if ($urandom_range(0, 3) == 0) v = 8'h06;
        wd(v);
      end else if (sel < 8) rd("R3 random read");
      else if (sel == 8) cyc(0, 1, 0, 8'h00, "R3 random index read");
      else begin
        pad_in = NP'($urandom);
        idle(1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule